// File: doc/BRIEF.md
# Indirect Control and Status Register Port

This block is the host-facing register file of a network controller. The host never addresses internal registers directly. It first writes a register number into an index port, then reads or writes the chosen register through a data port. A second data port uses the same index to reach a separate bank of bus configuration registers. A write to a fourth port performs a soft reset.

The central register is the control word at index 0. It carries four command bits: initialise, start, stop and transmit demand. It also holds the running state, an interrupt enable and seven sticky event flags. The host acknowledges a flag by writing 1 to it. Two summary bits and the interrupt line are derived from these flags.

The block also keeps a pair of registers that hold the address of the initialisation record, a feature word, a mode word and a read-only chip identifier. Towards the DMA side, initialisation is a handshake: an `init_req` pulse goes out and `init_done` comes back. Starting the controller emits a pulse that reloads the ring base pointers.

Top module: `nic_csr_port`

## Requirements
- R1: After reset, the control word (index 0) reads 0x0004 and the index port reads 0. The enables, pulses, `irq`, `iblk_addr`, `autopad` and `promisc` are all 0.
- R2: Port offsets are 0x10 for data, 0x14 for the index, 0x18 for soft reset and 0x1C for bus configuration data. The index is 7 bits wide and reads back at 0x14. A register index with no register behind it reads 0 on either data port, and any other offset reads 0.
- R3: Control word bits 8 to 14 are sticky flags. They are init-done, then `ev_in[0..5]` in order: tx done, rx done, memory error, missed frame, collision and babble. Writing 1 clears a flag and writing 0 leaves it unchanged. An event arriving in the same cycle as its clear wins.
- R4: Bit 15 is the OR of bits 11 to 14. Bit 7 is the OR of bits 8 to 14. Bit 6 (interrupt enable) takes the written value. `irq` is high exactly when bits 7 and 6 are both set.
- R5: Writing 1 to bit 1 (start) sets bit 1, bit 4 (tx on) and bit 5 (rx on), and clears bit 2 (stop). It also gives a one-cycle `ring_reload` pulse.
- R6: Writing 1 to bit 2 sets stop and clears start, tx on, rx on and init. Stop takes priority over start and init written in the same word, and no pulse is produced.
- R7: Writing 1 to bit 0 sets init, clears stop and gives one `init_req` pulse. A repeat write while init is pending produces no further pulse. `init_done` while init is pending clears bit 0 and sets bit 8. `init_done` at any other time is ignored.
- R8: Writing 1 to bit 3 while the controller is started gives a one-cycle `tx_demand` pulse. The write is ignored when the controller is not started, and bit 3 always reads 0.
- R9: Index 1 and index 2 hold the low and high halves of `iblk_addr`. Index 4 bit 11 drives `autopad` and index 15 bit 15 drives `promisc`. These four registers can be written only while stop is set; writes at other times are ignored.
- R10: Index 88 reads 0x1003 and index 89 reads 0x0262; together they form the identifier 0x2621003. Writes to either index are ignored.
- R11: Bus configuration index 20 stores its low 8 bits, which read back and drive `sw_style`. The value 0x02 selects 32-bit style.
- R12: A write to offset 0x18 returns the index, the control word and the lockable registers to their reset values. Bus configuration index 20 keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_off | input | 5 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| ev_in | input | 6 | Event pulses from the MAC and DMA side |
| init_done | input | 1 | Initialisation finished |
| init_req | output | 1 | Initialisation request pulse |
| ring_reload | output | 1 | Reload ring base pointers pulse |
| tx_demand | output | 1 | Transmit poll pulse |
| tx_en | output | 1 | Transmitter on |
| rx_en | output | 1 | Receiver on |
| irq | output | 1 | Interrupt request |
| iblk_addr | output | 32 | Initialisation record address |
| autopad | output | 1 | Auto-pad transmit frames |
| promisc | output | 1 | Promiscuous mode |
| sw_style | output | 8 | Software style field |

## Verification
The index/data path is driven by a table of writes and reads that steps through every implemented index and several empty ones. A wrong index comparison therefore shows up as a value appearing at the wrong index. The control word is then exercised with command combinations: stop together with start and init, init repeated while pending, and demand while stopped. These separate the priority rules from the plain set behaviour.

For the flags, single events are followed by a clear that lands in the same cycle as a new event. This distinguishes "set wins" from "clear wins", and 1-to-clear from a plain overwrite. Configuration writes are also attempted after the controller has left stop, and a soft reset is issued after the bus configuration register has been loaded. Together these show which storage each reset path and the stop lock reach.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

    localparam int HOST_W = 32;
    localparam int REG_W  = 16;
    localparam int OFF_W  = 5;
    localparam int N_EV   = 6;
    localparam int N_STAT = N_EV + 1;
    localparam int ID_W   = 28;
    localparam int N_LOCK = 4;
    localparam int STY_W  = 8;

    // host port offsets
    localparam logic [OFF_W-1:0] OFF_RDP  = 5'h10;
    localparam logic [OFF_W-1:0] OFF_RAP  = 5'h14;
    localparam logic [OFF_W-1:0] OFF_SRST = 5'h18;
    localparam logic [OFF_W-1:0] OFF_BDP  = 5'h1C;

    // register numbers
    localparam int IX_CTL   = 0;
    localparam int IX_ID_LO = 88;
    localparam int IX_ID_HI = 89;
    localparam int IX_STYLE = 20;

    // control word bit positions
    localparam int B_INIT  = 0;
    localparam int B_START = 1;
    localparam int B_STOP  = 2;
    localparam int B_TDMD  = 3;
    localparam int B_IENA  = 6;
    localparam int B_STAT0 = 8;
    localparam int B_AUTOPAD = 11;
    localparam int B_PROM    = 15;

    typedef struct packed {
        logic wr;
        logic init;
        logic start;
        logic stop;
        logic tdmd;
    } cmd_t;

    typedef struct packed {
        logic run;
        logic stop;
        logic init;
        logic txon;
        logic rxon;
        logic iena;
    } run_t;

    localparam run_t RUN_RST = '{run: 1'b0, stop: 1'b1, init: 1'b0,
                                 txon: 1'b0, rxon: 1'b0, iena: 1'b0};

    // register numbers of the configuration words writable only while stopped
    function automatic int lock_idx(input int k);
        case (k)
            0:       return 1;
            1:       return 2;
            2:       return 4;
            default: return 15;
        endcase
    endfunction

    // stop dominates start and init written in the same word
    function automatic cmd_t decode_cmd(input logic we, input logic [REG_W-1:0] w);
        cmd_t c;
        c.wr    = we;
        c.stop  = we & w[B_STOP];
        c.start = we & w[B_START] & ~w[B_STOP];
        c.init  = we & w[B_INIT]  & ~w[B_STOP];
        c.tdmd  = we & w[B_TDMD]  & ~w[B_STOP];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctl(input logic [N_STAT-1:0] stat,
                                                  input run_t st);
        logic [REG_W-1:0] v;
        v = '0;
        v[15]           = |stat[N_STAT-1:3];
        v[14:B_STAT0]   = stat;
        v[7]            = |stat;
        v[B_IENA]       = st.iena;
        v[5]            = st.rxon;
        v[4]            = st.txon;
        v[B_TDMD]       = 1'b0;
        v[B_STOP]       = st.stop;
        v[B_START]      = st.run;
        v[B_INIT]       = st.init;
        return v;
    endfunction

endpackage

// File: rtl/nic_csr_ctl.sv
module nic_csr_ctl
    import nic_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic [N_EV-1:0]  ev,
    input  logic             init_done,
    output logic [REG_W-1:0] csr_val,
    output logic             init_req,
    output logic             ring_reload,
    output logic             tx_demand,
    output logic             tx_en,
    output logic             rx_en,
    output logic             irq,
    output logic             stopped
);

    cmd_t              cmd;
    run_t              st_q, st_d;
    logic [N_STAT-1:0] stat_q, stat_d, stat_set, stat_clr;
    logic              req_d, rel_d, tdm_d, idone;
    logic              unused_wbits;

    assign cmd          = decode_cmd(wr_en, wdata);
    assign unused_wbits = ^{wdata[15], wdata[7], wdata[5:4]};

    always_comb begin
        st_d  = st_q;
        req_d = 1'b0;
        rel_d = 1'b0;
        tdm_d = cmd.tdmd & st_q.run;
        if (cmd.wr) st_d.iena = wdata[B_IENA];
        if (cmd.stop) begin
            st_d.stop = 1'b1;
            st_d.run  = 1'b0;
            st_d.txon = 1'b0;
            st_d.rxon = 1'b0;
            st_d.init = 1'b0;
        end else begin
            if (cmd.start) begin
                st_d.run  = 1'b1;
                st_d.txon = 1'b1;
                st_d.rxon = 1'b1;
                st_d.stop = 1'b0;
                rel_d     = 1'b1;
            end
            if (cmd.init && !st_q.init) begin
                st_d.init = 1'b1;
                st_d.stop = 1'b0;
                req_d     = 1'b1;
            end else if (init_done && st_q.init) begin
                st_d.init = 1'b0;
            end
        end
    end

    assign idone    = init_done & st_q.init & ~cmd.stop;
    assign stat_set = {ev, idone};
    assign stat_clr = cmd.wr ? wdata[B_STAT0 +: N_STAT] : '0;
    assign stat_d   = (stat_q & ~stat_clr) | stat_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= RUN_RST;
            stat_q      <= '0;
            init_req    <= 1'b0;
            ring_reload <= 1'b0;
            tx_demand   <= 1'b0;
        end else begin
            st_q        <= st_d;
            stat_q      <= stat_d;
            init_req    <= req_d;
            ring_reload <= rel_d;
            tx_demand   <= tdm_d;
        end
    end

    assign csr_val = pack_ctl(stat_q, st_q);
    assign irq     = (|stat_q) & st_q.iena;
    assign tx_en   = st_q.txon;
    assign rx_en   = st_q.rxon;
    assign stopped = st_q.stop;

endmodule

// File: rtl/nic_csr_cfg.sv
module nic_csr_cfg
    import nic_csr_pkg::*;
#(
    parameter int              IDX_W   = 7,
    parameter logic [ID_W-1:0] CHIP_ID = 28'h2621003
) (
    input  logic              clk,
    input  logic              hard_rst,
    input  logic              soft_rst,
    input  logic              csr_we,
    input  logic              bcr_we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [REG_W-1:0]  wdata,
    input  logic              stopped,
    output logic [REG_W-1:0]  csr_rd,
    output logic [REG_W-1:0]  bcr_rd,
    output logic [HOST_W-1:0] iblk_addr,
    output logic              autopad,
    output logic              promisc,
    output logic [STY_W-1:0]  sw_style
);

    localparam int HI_W = ID_W - REG_W;

    logic [REG_W-1:0] cfg_q [N_LOCK];
    logic [STY_W-1:0] style_q;

    for (genvar k = 0; k < N_LOCK; k++) begin : g_lock
        always_ff @(posedge clk) begin
            if (hard_rst || soft_rst)
                cfg_q[k] <= '0;
            else if (csr_we && stopped && idx == IDX_W'(lock_idx(k)))
                cfg_q[k] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (hard_rst)
            style_q <= '0;
        else if (bcr_we && idx == IDX_W'(IX_STYLE))
            style_q <= wdata[STY_W-1:0];
    end

    always_comb begin
        csr_rd = '0;
        for (int k = 0; k < N_LOCK; k++)
            if (idx == IDX_W'(lock_idx(k))) csr_rd = cfg_q[k];
        if (idx == IDX_W'(IX_ID_LO)) csr_rd = CHIP_ID[REG_W-1:0];
        if (idx == IDX_W'(IX_ID_HI)) csr_rd = {{(REG_W-HI_W){1'b0}}, CHIP_ID[ID_W-1:REG_W]};
    end

    assign bcr_rd    = (idx == IDX_W'(IX_STYLE)) ? {{(REG_W-STY_W){1'b0}}, style_q} : '0;
    assign iblk_addr = {cfg_q[1], cfg_q[0]};
    assign autopad   = cfg_q[2][B_AUTOPAD];
    assign promisc   = cfg_q[3][B_PROM];
    assign sw_style  = style_q;

endmodule

// File: rtl/nic_csr_port.sv
module nic_csr_port
    import nic_csr_pkg::*;
#(
    parameter int              IDX_W   = 7,
    parameter logic [ID_W-1:0] CHIP_ID = 28'h2621003
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [OFF_W-1:0]  host_off,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    input  logic [N_EV-1:0]   ev_in,
    input  logic              init_done,
    output logic              init_req,
    output logic              ring_reload,
    output logic              tx_demand,
    output logic              tx_en,
    output logic              rx_en,
    output logic              irq,
    output logic [HOST_W-1:0] iblk_addr,
    output logic              autopad,
    output logic              promisc,
    output logic [STY_W-1:0]  sw_style
);

    logic             soft_rst, rst_all;
    logic [IDX_W-1:0] idx_q;
    logic             wr_rdp, wr_bdp, wr_ctl, sel_ctl;
    logic [REG_W-1:0] csr0_w, cfg_rd, bcr_rd;
    logic             stop_w;
    logic             unused_hi;

    assign unused_hi = ^host_wdata[HOST_W-1:REG_W];
    assign soft_rst  = host_wr && host_off == OFF_SRST;
    assign rst_all   = rst || soft_rst;
    assign wr_rdp    = host_wr && host_off == OFF_RDP;
    assign wr_bdp    = host_wr && host_off == OFF_BDP;
    assign sel_ctl   = idx_q == IDX_W'(IX_CTL);
    assign wr_ctl    = wr_rdp && sel_ctl;

    always_ff @(posedge clk) begin
        if (rst_all)
            idx_q <= '0;
        else if (host_wr && host_off == OFF_RAP)
            idx_q <= host_wdata[IDX_W-1:0];
    end

    nic_csr_ctl u_ctl (
        .clk         (clk),
        .rst         (rst_all),
        .wr_en       (wr_ctl),
        .wdata       (host_wdata[REG_W-1:0]),
        .ev          (ev_in),
        .init_done   (init_done),
        .csr_val     (csr0_w),
        .init_req    (init_req),
        .ring_reload (ring_reload),
        .tx_demand   (tx_demand),
        .tx_en       (tx_en),
        .rx_en       (rx_en),
        .irq         (irq),
        .stopped     (stop_w)
    );

    nic_csr_cfg #(.IDX_W(IDX_W), .CHIP_ID(CHIP_ID)) u_cfg (
        .clk       (clk),
        .hard_rst  (rst),
        .soft_rst  (soft_rst),
        .csr_we    (wr_rdp && !sel_ctl),
        .bcr_we    (wr_bdp),
        .idx       (idx_q),
        .wdata     (host_wdata[REG_W-1:0]),
        .stopped   (stop_w),
        .csr_rd    (cfg_rd),
        .bcr_rd    (bcr_rd),
        .iblk_addr (iblk_addr),
        .autopad   (autopad),
        .promisc   (promisc),
        .sw_style  (sw_style)
    );

    always_comb begin
        host_rdata = '0;
        case (host_off)
            OFF_RDP: host_rdata[REG_W-1:0] = sel_ctl ? csr0_w : cfg_rd;
            OFF_RAP: host_rdata[IDX_W-1:0] = idx_q;
            OFF_BDP: host_rdata[REG_W-1:0] = bcr_rd;
            default: host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/nic_csr_port_chk.sv
module nic_csr_port_chk
    import nic_csr_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              host_wr,
    input logic [OFF_W-1:0]  host_off,
    input logic [HOST_W-1:0] host_wdata,
    input logic [IDX_W-1:0]  idx_q,
    input logic [REG_W-1:0]  csr0_w,
    input logic              init_req,
    input logic              ring_reload,
    input logic              tx_demand,
    input logic              tx_en,
    input logic              rx_en,
    input logic              irq,
    input logic [HOST_W-1:0] iblk_addr
);

    logic wr_data, unused_w;
    assign wr_data  = host_wr && host_off == OFF_RDP;
    assign unused_w = ^{host_wdata[HOST_W-1:3], host_wdata[1:0]};

    AST_RESET_STOPPED: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> csr0_w == 16'h0004);                                  // R1
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (csr0_w[B_IENA] && (|csr0_w[14:8])));                       // R4
    AST_RELOAD_RUNNING: assert property (@(posedge clk) disable iff (rst)
        ring_reload |-> (tx_en && rx_en && !csr0_w[B_STOP]));               // R5
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_data && idx_q == '0 && host_wdata[B_STOP])
            |=> (!tx_en && !rx_en && csr0_w[B_STOP] && !init_req && !ring_reload)); // R6
    AST_INIT_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        init_req |=> !init_req);                                             // R7
    AST_TDMD_RUNNING: assert property (@(posedge clk) disable iff (rst)
        tx_demand |-> $past(tx_en));                                         // R8
    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !csr0_w[B_STOP] && idx_q == IDX_W'(1)) |=> $stable(iblk_addr)); // R9

endmodule

bind nic_csr_port nic_csr_port_chk #(.IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_off    (host_off),
    .host_wdata  (host_wdata),
    .idx_q       (idx_q),
    .csr0_w      (csr0_w),
    .init_req    (init_req),
    .ring_reload (ring_reload),
    .tx_demand   (tx_demand),
    .tx_en       (tx_en),
    .rx_en       (rx_en),
    .irq         (irq),
    .iblk_addr   (iblk_addr)
);

// File: tb/nic_csr_port_tb_top.sv
`timescale 1ns/1ps
module nic_csr_port_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [4:0]  host_off = 5'h0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [5:0]  ev_in = '0;
    logic        init_done = 1'b0;
    logic        init_req, ring_reload, tx_demand, tx_en, rx_en, irq;
    logic [31:0] iblk_addr;
    logic        autopad, promisc;
    logic [7:0]  sw_style;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    nic_csr_port dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_off(host_off),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ev_in(ev_in),
        .init_done(init_done), .init_req(init_req), .ring_reload(ring_reload),
        .tx_demand(tx_demand), .tx_en(tx_en), .rx_en(rx_en), .irq(irq),
        .iblk_addr(iblk_addr), .autopad(autopad), .promisc(promisc),
        .sw_style(sw_style)
    );

    // {is_read, offset, data or expected value, requirement number}
    localparam int NV = 27;
    localparam logic [41:0] VEC [NV] = '{
        {1'b0, 5'h14, 32'h0000_0001, 4'd2},   // R2
        {1'b0, 5'h10, 32'h0000_BEEF, 4'd9},   // R9
        {1'b1, 5'h10, 32'h0000_BEEF, 4'd9},
        {1'b0, 5'h14, 32'h0000_0002, 4'd2},
        {1'b0, 5'h10, 32'h0000_1234, 4'd9},
        {1'b1, 5'h10, 32'h0000_1234, 4'd9},
        {1'b1, 5'h14, 32'h0000_0002, 4'd2},
        {1'b0, 5'h14, 32'h0000_0004, 4'd2},
        {1'b0, 5'h10, 32'h0000_0800, 4'd9},
        {1'b1, 5'h10, 32'h0000_0800, 4'd9},
        {1'b1, 5'h1C, 32'h0000_0000, 4'd2},
        {1'b0, 5'h14, 32'h0000_000F, 4'd2},
        {1'b0, 5'h10, 32'h0000_8000, 4'd9},
        {1'b1, 5'h10, 32'h0000_8000, 4'd9},
        {1'b0, 5'h14, 32'h0000_0058, 4'd10},  // R10
        {1'b1, 5'h10, 32'h0000_1003, 4'd10},
        {1'b0, 5'h10, 32'h0000_FFFF, 4'd10},
        {1'b1, 5'h10, 32'h0000_1003, 4'd10},
        {1'b0, 5'h14, 32'h0000_0059, 4'd10},
        {1'b1, 5'h10, 32'h0000_0262, 4'd10},
        {1'b0, 5'h14, 32'h0000_0014, 4'd11},  // R11
        {1'b0, 5'h1C, 32'h0000_0002, 4'd11},
        {1'b1, 5'h1C, 32'h0000_0002, 4'd11},
        {1'b1, 5'h10, 32'h0000_0000, 4'd2},
        {1'b0, 5'h14, 32'h0000_0000, 4'd2},
        {1'b1, 5'h10, 32'h0000_0004, 4'd1},   // R1
        {1'b1, 5'h00, 32'h0000_0000, 4'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] off, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_off = off; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] off, output logic [31:0] d);
        host_off = off;
        #1;
        d = host_rdata;
    endtask

    task automatic ev_pulse(input logic [5:0] e, input logic idn);
        @(negedge clk);
        ev_in = e; init_done = idn;
        @(negedge clk);
        ev_in = '0; init_done = 1'b0;
    endtask

    task automatic chk_ctl(input string req, input logic [15:0] exp);
        logic [31:0] v;
        rd(5'h10, v);
        check(req, v, {16'h0, exp});
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk_ctl("R1 ctl", 16'h0004);
        rd(5'h14, v);
        check("R1 index", v, 32'h0);
        check("R1 outputs", {24'h0, init_req, ring_reload, tx_demand, tx_en, rx_en, irq, autopad, promisc}, 32'h0);
        check("R1 iblk", iblk_addr, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][41]) begin
                rd(VEC[i][40:36], v);
                check($sformatf("R%0d vec%0d", VEC[i][3:0], i), v, VEC[i][35:4]);
            end else begin
                wr(VEC[i][40:36], VEC[i][35:4]);
            end
        end
        check("R9 iblk_addr", iblk_addr, 32'h1234_BEEF);
        check("R9 autopad/promisc", {30'h0, autopad, promisc}, 32'h3);
        check("R11 sw_style", {24'h0, sw_style}, 32'h2);

        // R7 init handshake
        wr(5'h10, 32'h0001);
        check("R7 init_req pulse", {31'h0, init_req}, 32'h1);
        chk_ctl("R7 init pending", 16'h0001);
        @(negedge clk);
        check("R7 init_req single", {31'h0, init_req}, 32'h0);
        wr(5'h10, 32'h0001);
        check("R7 no repeat pulse", {31'h0, init_req}, 32'h0);
        ev_pulse(6'h0, 1'b1);
        chk_ctl("R7 init done", 16'h0180);
        check("R4 irq masked", {31'h0, irq}, 32'h0);
        ev_pulse(6'h0, 1'b1);
        chk_ctl("R7 stray done ignored", 16'h0180);

        // R9 lock while not stopped
        wr(5'h14, 32'h1);
        wr(5'h10, 32'h5555);
        rd(5'h10, v);
        check("R9 locked write", v, 32'h0000_BEEF);
        wr(5'h14, 32'h0);

        // R4 enable and summary
        wr(5'h10, 32'h0040);
        check("R4 irq on", {31'h0, irq}, 32'h1);
        chk_ctl("R4 ctl", 16'h01C0);
        wr(5'h10, 32'h0140);
        chk_ctl("R3 clear idone", 16'h0040);
        check("R4 irq off", {31'h0, irq}, 32'h0);

        // R5 start
        wr(5'h10, 32'h0042);
        check("R5 reload pulse", {31'h0, ring_reload}, 32'h1);
        chk_ctl("R5 ctl", 16'h0072);
        check("R5 enables", {30'h0, tx_en, rx_en}, 32'h3);
        @(negedge clk);
        check("R5 reload single", {31'h0, ring_reload}, 32'h0);

        // R8 demand while running
        wr(5'h10, 32'h0048);
        check("R8 tx_demand", {31'h0, tx_demand}, 32'h1);
        chk_ctl("R8 bit3 reads 0", 16'h0072);

        // R3 events, summaries, clear collision
        ev_pulse(6'h04, 1'b0);
        chk_ctl("R3 mem err", 16'h88F2);
        check("R4 irq event", {31'h0, irq}, 32'h1);
        ev_pulse(6'h10, 1'b0);
        chk_ctl("R3 collision", 16'hA8F2);
        wr(5'h10, 32'h0840);
        chk_ctl("R3 w1c keeps others", 16'hA0F2);
        @(negedge clk);
        host_wr = 1'b1; host_off = 5'h10; host_wdata = 32'h2240; ev_in = 6'h01;
        @(negedge clk);
        host_wr = 1'b0; ev_in = '0;
        chk_ctl("R3 set beats clear", 16'h02F2);

        // R6 stop priority
        wr(5'h10, 32'h0047);
        check("R6 no pulses", {30'h0, init_req, ring_reload}, 32'h0);
        chk_ctl("R6 stop wins", 16'h02C4);
        check("R6 enables off", {30'h0, tx_en, rx_en}, 32'h0);
        check("R4 irq stays", {31'h0, irq}, 32'h1);

        // R8 demand while stopped
        wr(5'h10, 32'h0048);
        check("R8 demand ignored", {31'h0, tx_demand}, 32'h0);

        // R12 soft reset
        wr(5'h18, 32'h0);
        rd(5'h14, v);
        check("R12 index", v, 32'h0);
        chk_ctl("R12 ctl", 16'h0004);
        check("R12 iblk", iblk_addr, 32'h0);
        check("R12 autopad", {31'h0, autopad}, 32'h0);
        check("R12 style kept", {24'h0, sw_style}, 32'h2);
        wr(5'h14, 32'h14);
        rd(5'h1C, v);
        check("R12 bcr kept", v, 32'h2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule